// File: doc/BRIEF.md
# Triggered Sample Clock Timing Engine

This block paces a digital input acquisition. It picks one of three timebase enables, waits for software to arm it and for a start trigger to arrive, then counts a programmable number of timebase ticks before the first sample pulse. After that pulse it emits one pulse every N ticks of the selected timebase. Each pulse is one system clock wide. A separate output carries the same pulse with inverted polarity, for an output terminal.

A pause input holds back pulses while it is asserted. In finite mode the engine stops by itself after a programmed number of samples. In either mode a software stop ends the run. An external sample clock may replace the internal divider. In that case the engine forwards the rising edges of the external input, but only while the acquisition is running. The block reports a running sample count, a busy flag and a done flag.

Top module: `smpclk_engine`

## Requirements
- R1: `tb_sel` picks the timebase enable: 0 selects `tb_src_en[0]` (fast), 1 selects `tb_src_en[1]` (medium), 2 selects `tb_src_en[2]` (slow), and 3 falls back to `tb_src_en[0]`. Only the selected enable advances the delay and the divider.
- R2: After reset `dly_q` reads 2, `smp_pulse` is 0, `smp_pulse_n` is 1, `smp_count` is 0, and both `busy` and `done` are 0.
- R3: `arm` in idle moves the engine to waiting-for-start (`busy` rises) and clears `smp_count`. `arm` when `done` is high returns the engine to idle (`busy` and `done` both low). `start_trig` has no effect except while waiting for start.
- R4: With the internal clock, the first pulse follows the D-th selected tick after the cycle that accepted the start trigger, one clock after that tick. D is `dly_q`, and 0 counts as 1.
- R5: Each later internal pulse comes N selected ticks after the one before it, where N is `div_n` raised to a floor of 2.
- R6: While `ext_sel` is 1 the divider produces no pulses. Instead, each rising edge of `ext_clk_in` seen during the running phase gives one pulse on the following cycle.
- R7: No pulse appears in idle, while waiting for start, or in done, whatever `ext_clk_in` and the timebases do.
- R8: A pulse due while `pause_trig` is high is dropped and does not count. The divider keeps counting ticks during the pause.
- R9: In finite mode (`finite_mode`=1), the cycle that shows pulse number `sample_target` also shows `done`=1 and `busy`=0. A target of 0 counts as 1.
- R10: `sw_stop` while busy sends the engine to done on the next cycle, and no pulse is emitted for that cycle. The count then stays frozen.
- R11: `smp_pulse_n` is always the complement of `smp_pulse`.
- R12: `smp_count` rises by exactly one in the same cycle as each emitted pulse and does not change otherwise, except when it is cleared by R3.
- R13: In continuous mode (`finite_mode`=0) the engine keeps running past `sample_target` until it receives `sw_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_src_en | input | NSRC | One-cycle timebase enables: bit 0 fast, bit 1 medium, bit 2 slow |
| tb_sel | input | SEL_W | Timebase select |
| ext_sel | input | 1 | Use the external sample clock instead of the divider |
| ext_clk_in | input | 1 | External sample clock, synchronous to `clk` |
| arm | input | 1 | Software arm command (also releases done) |
| start_trig | input | 1 | Start trigger |
| sw_stop | input | 1 | Software stop command |
| pause_trig | input | 1 | Pause level |
| finite_mode | input | 1 | 1 = stop after `sample_target` samples |
| dly_wr | input | 1 | Write strobe for the delay register |
| dly_wdata | input | CNT_W | New delay value, in ticks |
| div_n | input | CNT_W | Tick divisor between samples |
| sample_target | input | CNT_W | Number of samples in finite mode |
| dly_q | output | CNT_W | Current delay register |
| smp_pulse | output | 1 | One-cycle sample clock pulse |
| smp_pulse_n | output | 1 | Inverted copy of `smp_pulse` |
| smp_count | output | CNT_W | Samples emitted in this run |
| busy | output | 1 | Waiting for start, delaying, or running |
| done | output | 1 | Run ended; waiting for `arm` |

## Verification
The finite-mode bound assumes that `finite_mode` and `sample_target` stay steady for the whole run. The assertions also treat `ext_clk_in` as already synchronous to `clk`. The bench honours both assumptions. It changes configuration only while the engine is idle or done, and it drives every input on the falling clock edge, including the external clock, which has two-cycle phases. The timebase enables are strobes at fixed periods, so the bench can count the exact tick that should produce each pulse.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_DLY  = 3'd2,
    ST_RUN  = 3'd3,
    ST_DONE = 3'd4
  } eng_state_t;

endpackage

// File: rtl/smpclk_tbsel.sv
module smpclk_tbsel #(
  parameter  int NSRC  = 3,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  src_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  // an out-of-range code falls back to source 0
  always_comb begin
    tick = src_en[0];
    for (int i = 1; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) tick = src_en[i];
    end
  end

endmodule

// File: rtl/smpclk_edge.sv
module smpclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;

endmodule

// File: rtl/smpclk_divider.sv
module smpclk_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  // a count of 0 or 1 expires on the next tick
  assign expire = tick & (cnt_q <= W'(1));

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (expire) cnt_q <= reload;
    else if (tick)   cnt_q <= cnt_q - W'(1);
  end

  AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(expire) && !$past(load)) |-> (cnt_q >= W'(2))); // R5

endmodule

// File: rtl/smpclk_engine.sv
module smpclk_engine
  import smpclk_pkg::*;
#(
  parameter  int CNT_W   = 32,
  parameter  int NSRC    = 3,
  parameter  int DLY_RST = 2,
  parameter  int DIV_MIN = 2,
  localparam int SEL_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  tb_src_en,
  input  logic [SEL_W-1:0] tb_sel,
  input  logic             ext_sel,
  input  logic             ext_clk_in,
  input  logic             arm,
  input  logic             start_trig,
  input  logic             sw_stop,
  input  logic             pause_trig,
  input  logic             finite_mode,
  input  logic             dly_wr,
  input  logic [CNT_W-1:0] dly_wdata,
  input  logic [CNT_W-1:0] div_n,
  input  logic [CNT_W-1:0] sample_target,
  output logic [CNT_W-1:0] dly_q,
  output logic             smp_pulse,
  output logic             smp_pulse_n,
  output logic [CNT_W-1:0] smp_count,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] DIV_FLOOR = CNT_W'(DIV_MIN);
  localparam logic [CNT_W-1:0] DLY_INIT  = CNT_W'(DLY_RST);

  eng_state_t state_q, state_d;

  logic             tb_tick, ext_rise, expire;
  logic             active, div_tick, div_load;
  logic             int_fire, ext_fire, emit, last_smp;
  logic [CNT_W-1:0] reload_val, tgt_eff;

  // ---------------- timebase selection ----------------
  smpclk_tbsel #(.NSRC(NSRC)) u_tbsel (
    .src_en (tb_src_en),
    .sel    (tb_sel),
    .tick   (tb_tick)
  );

  // ---------------- external clock edge ----------------
  smpclk_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_clk_in),
    .rise (ext_rise)
  );

  // ---------------- delay register ----------------
  always_ff @(posedge clk) begin
    if (rst)         dly_q <= DLY_INIT;
    else if (dly_wr) dly_q <= dly_wdata;
  end

  // ---------------- shared delay / divide counter ----------------
  assign active     = (state_q == ST_DLY) || (state_q == ST_RUN);
  assign div_tick   = tb_tick & active;
  assign div_load   = (state_q == ST_WAIT) & start_trig & ~sw_stop;
  assign reload_val = (div_n < DIV_FLOOR) ? DIV_FLOOR : div_n;

  smpclk_divider #(.W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (div_load),
    .load_val (dly_q),
    .tick     (div_tick),
    .reload   (reload_val),
    .expire   (expire)
  );

  // ---------------- pulse qualification ----------------
  assign int_fire = expire & ~ext_sel;
  assign ext_fire = ext_sel & ext_rise & (state_q == ST_RUN);
  assign emit     = (int_fire | ext_fire) & ~pause_trig & ~sw_stop;
  assign tgt_eff  = (sample_target == '0) ? CNT_W'(1) : sample_target;
  assign last_smp = finite_mode & ((smp_count + CNT_W'(1)) >= tgt_eff);

  // ---------------- sequencer ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (arm) state_d = ST_WAIT;
      ST_WAIT: begin
        if (sw_stop)         state_d = ST_DONE;
        else if (start_trig) state_d = ST_DLY;
      end
      ST_DLY: begin
        if (sw_stop)                state_d = ST_DONE;
        else if (emit && last_smp)  state_d = ST_DONE;
        else if (expire)            state_d = ST_RUN;
      end
      ST_RUN: begin
        if (sw_stop)                state_d = ST_DONE;
        else if (emit && last_smp)  state_d = ST_DONE;
      end
      ST_DONE: if (arm) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      smp_pulse   <= 1'b0;
      smp_pulse_n <= 1'b1;
      smp_count   <= '0;
    end else begin
      state_q     <= state_d;
      busy        <= (state_d == ST_WAIT) || (state_d == ST_DLY) || (state_d == ST_RUN);
      done        <= (state_d == ST_DONE);
      smp_pulse   <= emit;
      smp_pulse_n <= ~emit;
      if ((state_q == ST_IDLE) && arm) smp_count <= '0;
      else if (emit)                   smp_count <= smp_count + CNT_W'(1);
    end
  end

  // ---------------- assertions ----------------
  AST_PULSE_IN_ACQ: assert property (@(posedge clk) disable iff (rst)
    smp_pulse |-> ($past(state_q) == ST_DLY || $past(state_q) == ST_RUN)); // R7

  AST_PAUSE_GATES: assert property (@(posedge clk) disable iff (rst)
    smp_pulse |-> !$past(pause_trig)); // R8

  AST_INV_COPY: assert property (@(posedge clk) disable iff (rst)
    smp_pulse_n != smp_pulse); // R11

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    smp_pulse |-> (smp_count == $past(smp_count) + CNT_W'(1))); // R12

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!smp_pulse && !$past(state_q == ST_IDLE && arm)) |-> $stable(smp_count)); // R12

  AST_FINITE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && finite_mode && sample_target != '0) |-> (smp_count < sample_target)); // R9

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    $past(sw_stop && (state_q == ST_WAIT || state_q == ST_DLY || state_q == ST_RUN))
      |-> (state_q == ST_DONE && !smp_pulse)); // R10

  AST_START_ONLY_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DLY && $past(state_q) != ST_DLY)
      |-> ($past(state_q) == ST_WAIT && $past(start_trig))); // R3

endmodule

// File: tb/smpclk_engine_tb.sv
module smpclk_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  tb_src_en;
  logic [1:0]  tb_sel;
  logic        ext_sel, ext_clk_in, arm, start_trig, sw_stop, pause_trig, finite_mode;
  logic        dly_wr;
  logic [31:0] dly_wdata, div_n, sample_target;
  logic [31:0] dly_q, smp_count;
  logic        smp_pulse, smp_pulse_n, busy, done;

  always #4 clk = ~clk;

  smpclk_engine dut_i (
    .clk(clk), .rst(rst), .tb_src_en(tb_src_en), .tb_sel(tb_sel),
    .ext_sel(ext_sel), .ext_clk_in(ext_clk_in), .arm(arm), .start_trig(start_trig),
    .sw_stop(sw_stop), .pause_trig(pause_trig), .finite_mode(finite_mode),
    .dly_wr(dly_wr), .dly_wdata(dly_wdata), .div_n(div_n), .sample_target(sample_target),
    .dly_q(dly_q), .smp_pulse(smp_pulse), .smp_pulse_n(smp_pulse_n),
    .smp_count(smp_count), .busy(busy), .done(done)
  );

  // vector table: sel, write-delay flag, delay, divisor, target, expected first tick
  localparam int NV = 6;
  localparam int V_SEL   [NV] = '{0, 1, 2, 3, 0, 1};
  localparam int V_WR    [NV] = '{0, 1, 1, 1, 1, 1};
  localparam int V_DLY   [NV] = '{0, 5, 1, 0, 3, 2};
  localparam int V_DIV   [NV] = '{3, 2, 4, 1, 0, 5};
  localparam int V_TGT   [NV] = '{4, 3, 2, 3, 0, 5};
  localparam int V_FIRST [NV] = '{2, 5, 1, 1, 3, 2};

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // timebase strobes: fast every 2, medium every 3, slow every 5 cycles
  always @(negedge clk) begin
    cyc++;
    tb_src_en[0] = (cyc % 2 == 0);
    tb_src_en[1] = (cyc % 3 == 0);
    tb_src_en[2] = (cyc % 5 == 0);
  end

  // monitor state
  int  pulses = 0, pause_hits = 0, inv_bad = 0, timing_bad = 0;
  int  ticks = 0, kidx = 0, first_e = 0, div_e = 0;
  bit  meas = 0, timing_on = 0, last_pause = 0;

  function automatic bit sel_en();
    case (tb_sel)
      2'd1:    return tb_src_en[1];
      2'd2:    return tb_src_en[2];
      default: return tb_src_en[0];
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (smp_pulse) begin
        pulses++;
        if (last_pause) pause_hits++;
        if (timing_on) begin
          kidx++;
          if (ticks != first_e + (kidx - 1) * div_e) begin
            timing_bad++;
            $display("  pulse %0d at tick %0d, expected tick %0d", kidx, ticks,
                     first_e + (kidx - 1) * div_e);
          end
        end
      end
      if (smp_pulse_n == smp_pulse) inv_bad++;
      if (meas && sel_en()) ticks++;
      last_pause = pause_trig;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_trig = 1'b1;
    @(negedge clk); start_trig = 1'b0; meas = 1'b1;
  endtask

  task automatic do_stop();
    @(negedge clk); sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
  endtask

  task automatic wr_delay(input int v);
    @(negedge clk); dly_wr = 1'b1; dly_wdata = v;
    @(negedge clk); dly_wr = 1'b0;
  endtask

  task automatic clear_mon();
    pulses = 0; pause_hits = 0; timing_bad = 0; ticks = 0; kidx = 0; meas = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tb_sel = 2'd0; ext_sel = 1'b0; ext_clk_in = 1'b0; arm = 1'b0;
    start_trig = 1'b0; sw_stop = 1'b0; pause_trig = 1'b0; finite_mode = 1'b1;
    dly_wr = 1'b0; dly_wdata = '0; div_n = 32'd2; sample_target = 32'd1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk(dly_q == 32'd2, "R2", "delay after reset", dly_q, 2);
    chk(smp_pulse == 1'b0 && smp_pulse_n == 1'b1, "R2", "pulse pair after reset",
        {smp_pulse, smp_pulse_n}, 1);
    chk(smp_count == 0, "R2", "count after reset", smp_count, 0);
    chk(busy == 1'b0 && done == 1'b0, "R2", "busy/done after reset", {busy, done}, 0);

    // table-driven finite runs (R1, R4, R5, R9, R12)
    for (int v = 0; v < NV; v++) begin
      int dv, tg;
      dv = (V_DIV[v] < 2) ? 2 : V_DIV[v];
      tg = (V_TGT[v] == 0) ? 1 : V_TGT[v];
      if (done) do_arm();
      @(negedge clk);
      tb_sel = V_SEL[v][1:0]; div_n = V_DIV[v]; sample_target = V_TGT[v];
      finite_mode = 1'b1; ext_sel = 1'b0;
      if (V_WR[v] != 0) wr_delay(V_DLY[v]);
      do_arm();
      chk(busy == 1'b1, "R3", "busy after arm", busy, 1);
      clear_mon();
      first_e = V_FIRST[v]; div_e = dv; timing_on = 1'b1;
      do_start();
      for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
      @(negedge clk);
      chk(timing_bad == 0, "R4/R5 R1", "pulse placement errors", timing_bad, 0);
      chk(pulses == tg, "R9", "pulses in finite run", pulses, tg);
      chk(smp_count == tg, "R12", "final count", smp_count, tg);
      chk(busy == 1'b0 && done == 1'b1, "R9", "busy/done after finite run", {busy, done}, 1);
      timing_on = 1'b0; meas = 1'b0;
    end

    // R8 pause gating and R13 continuous mode
    do_arm();
    @(negedge clk);
    tb_sel = 2'd0; div_n = 32'd2; sample_target = 32'd3; finite_mode = 1'b0;
    wr_delay(1);
    do_arm();
    clear_mon();
    do_start();
    repeat (40) @(negedge clk);
    pause_trig = 1'b1;
    repeat (40) @(negedge clk);
    pause_trig = 1'b0;
    repeat (40) @(negedge clk);
    chk(pause_hits == 0, "R8", "pulses after paused cycles", pause_hits, 0);
    chk(pulses > 0 && pulses <= 21, "R8", "pulses with pause window", pulses, 20);
    chk(smp_count == pulses, "R12", "count vs observed pulses", smp_count, pulses);
    chk(busy == 1'b1 && smp_count > 3, "R13", "still running past target", busy, 1);

    // R10 software stop
    do_stop();
    chk(busy == 1'b0 && done == 1'b1, "R10", "busy/done after stop", {busy, done}, 1);
    begin
      int c0, p0;
      c0 = smp_count; p0 = pulses;
      repeat (20) @(negedge clk);
      chk(smp_count == c0, "R10", "count frozen after stop", smp_count, c0);
      chk(pulses == p0, "R10", "no pulses after stop", pulses, p0);
    end

    // R6 external sample clock
    do_arm();
    @(negedge clk);
    ext_sel = 1'b1; finite_mode = 1'b0; tb_sel = 2'd0;
    do_arm();
    clear_mon();
    do_start();
    repeat (30) @(negedge clk);
    chk(pulses == 0, "R6", "internal pulses with external selected", pulses, 0);
    for (int e = 0; e < 5; e++) begin
      ext_clk_in = 1'b1; repeat (2) @(negedge clk);
      ext_clk_in = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(pulses == 5, "R6", "pulses from external edges", pulses, 5);
    chk(smp_count == 5, "R6", "count from external edges", smp_count, 5);
    do_stop();

    // R3 arm from done returns to idle; R7 nothing passes while idle
    do_arm();
    chk(busy == 1'b0 && done == 1'b0, "R3", "idle after arm from done", {busy, done}, 0);
    clear_mon();
    @(negedge clk); start_trig = 1'b1;
    @(negedge clk); start_trig = 1'b0;
    for (int e = 0; e < 4; e++) begin
      ext_clk_in = 1'b1; repeat (2) @(negedge clk);
      ext_clk_in = 1'b0; repeat (2) @(negedge clk);
    end
    chk(busy == 1'b0, "R3", "start ignored in idle", busy, 0);
    chk(pulses == 0, "R7", "pulses while idle", pulses, 0);

    chk(inv_bad == 0, "R11", "cycles with non-inverted copy", inv_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule